// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block is the per-channel datapath of a direct-memory-access channel. A channel is first programmed in one cycle. That cycle loads a page byte, a 16-bit start address, a 16-bit count, a mode byte and a width select. After that, every one-cycle transfer-done strobe advances the channel: the current address steps up by one and the count steps down by one. The block presents a registered 24-bit physical memory address for the next transfer, the transfer direction, and the live current address and count.

On a byte-wide channel the page byte supplies the top eight physical address bits. On a word-wide channel the address is shifted left by one bit, the lowest physical bit is forced to zero, and the lowest page bit is dropped. The 16-bit address register wraps on its own and never carries into the page, so a run of transfers stays inside one 64 KB window (byte channel) or one 128 KB window (word channel).

When the count runs out, the block gives a one-cycle terminal-count pulse. It then either masks itself or, with auto-initialisation, reloads its start values. In cascade mode it generates no addresses and only passes a request up and an acknowledge down.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset the channel is masked (`chan_masked_o`=1). `mem_addr_o`, `cur_addr_o`, `cur_cnt_o`, `tc_o`, `casc_req_o` and `casc_ack_o` are all 0.
- R2: On a byte channel (`word_i`=0 at load), `mem_addr_o[23:16]` equals the page byte and `mem_addr_o[15:0]` equals the current address. `mem_addr_o` updates in the same clock edge as the current address.
- R3: On a word channel (`word_i`=1 at load), `mem_addr_o[0]` is 0, `mem_addr_o[16:1]` equals the current address, `mem_addr_o[23:17]` equals page bits 7:1, and page bit 0 has no effect.
- R4: Each accepted strobe raises the current address by 1 and lowers the count by 1, both modulo 2^16. An address step from 0xFFFF gives 0x0000 and leaves the page-derived address bits unchanged.
- R5: A loaded count N gives exactly N+1 accepted strobes up to terminal count. `tc_o` is high for the one cycle after the strobe that found the count at 0.
- R6: Without auto-initialisation (mode bit 4 = 0), terminal count sets `chan_masked_o`. The address still steps and the count reads 0xFFFF.
- R7: With auto-initialisation (mode bit 4 = 1), terminal count restores the loaded address and count and leaves the channel unmasked.
- R8: While the channel is masked, strobes are ignored and the current address and count hold.
- R9: `dir_o` equals bit 3 of the loaded mode byte. Mode 0x44 gives 0 (I/O to memory) and 0x48 gives 1 (memory to I/O).
- R10: With mode bits 7:6 = 11 (cascade, e.g. 0xC0) and the channel unmasked, `casc_req_o` follows `casc_req_i` and `casc_ack_o` follows `casc_ack_i`, each one cycle later. Strobes are ignored. In any other mode, or while masked, both outputs are 0.
- R11: A load clears the mask and replaces page, address, count, mode and width. A load takes priority over a strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Program the channel from the inputs below |
| page_i | input | 8 | Page byte |
| addr_i | input | 16 | Start address |
| cnt_i | input | 16 | Count minus one |
| mode_i | input | 8 | Mode byte |
| word_i | input | 1 | 1 = word-wide channel |
| xfer_i | input | 1 | One-cycle transfer-done strobe |
| casc_req_i | input | 1 | Request from the downstream controller |
| casc_ack_i | input | 1 | Acknowledge from upstream |
| mem_addr_o | output | 24 | Physical memory address |
| dir_o | output | 1 | 1 = memory to I/O |
| tc_o | output | 1 | Terminal-count pulse |
| cur_addr_o | output | 16 | Current address register |
| cur_cnt_o | output | 16 | Current count register |
| chan_masked_o | output | 1 | Channel mask bit |
| casc_req_o | output | 1 | Forwarded request |
| casc_ack_o | output | 1 | Forwarded acknowledge |

## Verification
The bench starts a byte channel near 0xFFFF so the address wrap shows up. A design that carried into the page would move `mem_addr_o[23:16]`. Word channels use odd page bytes: a design that did not drop page bit 0, or did not shift, gives a wrong address. Loaded counts of 0 and 1 catch an off-by-one terminal count, which would come one strobe early or late. Auto-initialisation, strobes on a masked channel, cascade with strobes and a load in the same cycle as a strobe each show up as stray movement of the current registers or the mask.

// File: rtl/dma_gen_pkg.sv
package dma_gen_pkg;

  typedef struct packed {
    logic cascade;
    logic autoinit;
    logic mem_to_io;
  } chan_mode_t;

  function automatic chan_mode_t decode_mode(input logic [7:0] m);
    chan_mode_t r;
    r.cascade   = (m[7:6] == 2'b11);
    r.autoinit  = m[4];
    r.mem_to_io = m[3];
    return r;
  endfunction

endpackage

// File: rtl/dma_addr_map.sv
module dma_addr_map #(
  parameter int ADDR_W = 24,
  parameter int REG_W  = 16,
  localparam int PAGE_W = ADDR_W - REG_W
) (
  input  logic [PAGE_W-1:0] page,
  input  logic [REG_W-1:0]  cur,
  input  logic              word,
  output logic [ADDR_W-1:0] phys
);
  logic [ADDR_W-1:0] byte_phys;
  logic [ADDR_W-1:0] word_phys;

  assign byte_phys = {page, cur};
  assign word_phys = {page[PAGE_W-1:1], cur, 1'b0};
  assign phys      = word ? word_phys : byte_phys;

  logic page_lsb_unused;
  assign page_lsb_unused = page[0];
endmodule

// File: rtl/dma_cnt_core.sv
module dma_cnt_core #(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [REG_W-1:0] addr_i,
  input  logic [REG_W-1:0] cnt_i,
  input  logic             xfer_i,
  input  logic             cascade_i,
  input  logic             autoinit_i,
  output logic [REG_W-1:0] addr_d,
  output logic [REG_W-1:0] addr_q,
  output logic [REG_W-1:0] cnt_q,
  output logic             mask_q,
  output logic             tc_q
);
  logic [REG_W-1:0] base_addr_q, base_cnt_q;
  logic [REG_W-1:0] cnt_d;
  logic             mask_d, tc_d, take;

  assign take = xfer_i && !mask_q && !cascade_i;

  always_comb begin
    addr_d = addr_q;
    cnt_d  = cnt_q;
    mask_d = mask_q;
    tc_d   = 1'b0;
    if (load_i) begin
      addr_d = addr_i;
      cnt_d  = cnt_i;
      mask_d = 1'b0;
    end else if (take) begin
      addr_d = addr_q + REG_W'(1);
      cnt_d  = cnt_q - REG_W'(1);
      if (cnt_q == '0) begin
        tc_d = 1'b1;
        if (autoinit_i) begin
          addr_d = base_addr_q;
          cnt_d  = base_cnt_q;
        end else begin
          mask_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q      <= '0;
      cnt_q       <= '0;
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      mask_q      <= 1'b1;
      tc_q        <= 1'b0;
    end else begin
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
      mask_q <= mask_d;
      tc_q   <= tc_d;
      if (load_i) begin
        base_addr_q <= addr_i;
        base_cnt_q  <= cnt_i;
      end
    end
  end

  assert_tc_source_R5: assert property (@(posedge clk) disable iff (rst)
    tc_q |-> $past(xfer_i && !load_i && !cascade_i && !mask_q && cnt_q == '0));

  assert_masked_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (mask_q && !load_i) |=> (addr_q == $past(addr_q) && cnt_q == $past(cnt_q)));

  assert_tc_masks_R6: assert property (@(posedge clk) disable iff (rst)
    (take && !load_i && cnt_q == '0 && !autoinit_i) |=> mask_q);

  assert_autoinit_open_R7: assert property (@(posedge clk) disable iff (rst)
    (take && !load_i && cnt_q == '0 && autoinit_i) |=> (!mask_q && tc_q));
endmodule

// File: rtl/dma_cascade_fwd.sv
module dma_cascade_fwd (
  input  logic clk,
  input  logic rst,
  input  logic pass_i,
  input  logic req_i,
  input  logic ack_i,
  output logic req_o,
  output logic ack_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req_o <= 1'b0;
      ack_o <= 1'b0;
    end else begin
      req_o <= pass_i & req_i;
      ack_o <= pass_i & ack_i;
    end
  end

  assert_blocked_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !pass_i |=> (!req_o && !ack_o));
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dma_gen_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int REG_W  = 16,
  localparam int PAGE_W = ADDR_W - REG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [REG_W-1:0]  addr_i,
  input  logic [REG_W-1:0]  cnt_i,
  input  logic [7:0]        mode_i,
  input  logic              word_i,
  input  logic              xfer_i,
  input  logic              casc_req_i,
  input  logic              casc_ack_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              dir_o,
  output logic              tc_o,
  output logic [REG_W-1:0]  cur_addr_o,
  output logic [REG_W-1:0]  cur_cnt_o,
  output logic              chan_masked_o,
  output logic              casc_req_o,
  output logic              casc_ack_o
);
  chan_mode_t        mode_q;
  logic [PAGE_W-1:0] page_q, page_d;
  logic              word_q, word_d;
  logic [REG_W-1:0]  addr_d;
  logic [ADDR_W-1:0] phys_d;

  logic mode_bits_unused;
  assign mode_bits_unused = ^{mode_i[5], mode_i[2:0]};

  assign page_d = load_i ? page_i : page_q;
  assign word_d = load_i ? word_i : word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= '0;
      page_q     <= '0;
      word_q     <= 1'b0;
      mem_addr_o <= '0;
    end else begin
      if (load_i) mode_q <= decode_mode(mode_i);
      page_q     <= page_d;
      word_q     <= word_d;
      mem_addr_o <= phys_d;
    end
  end

  assign dir_o = mode_q.mem_to_io;

  dma_cnt_core #(.REG_W(REG_W)) u_core (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load_i),
    .addr_i     (addr_i),
    .cnt_i      (cnt_i),
    .xfer_i     (xfer_i),
    .cascade_i  (mode_q.cascade),
    .autoinit_i (mode_q.autoinit),
    .addr_d     (addr_d),
    .addr_q     (cur_addr_o),
    .cnt_q      (cur_cnt_o),
    .mask_q     (chan_masked_o),
    .tc_q       (tc_o)
  );

  dma_addr_map #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_map (
    .page (page_d),
    .cur  (addr_d),
    .word (word_d),
    .phys (phys_d)
  );

  dma_cascade_fwd u_casc (
    .clk    (clk),
    .rst    (rst),
    .pass_i (mode_q.cascade && !chan_masked_o),
    .req_i  (casc_req_i),
    .ack_i  (casc_ack_i),
    .req_o  (casc_req_o),
    .ack_o  (casc_ack_o)
  );

  assert_word_even_R3: assert property (@(posedge clk) disable iff (rst)
    word_q |-> (mem_addr_o[0] == 1'b0));

  assert_page_no_carry_R4: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> (mem_addr_o[ADDR_W-1:REG_W+1] == $past(mem_addr_o[ADDR_W-1:REG_W+1])));

  assert_byte_map_R2: assert property (@(posedge clk) disable iff (rst)
    !word_q |-> (mem_addr_o[REG_W-1:0] == cur_addr_o));
endmodule

// File: tb/sim_dma_addr_gen.sv
module sim_dma_addr_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load_i = 0, word_i = 0, xfer_i = 0, casc_req_i = 0, casc_ack_i = 0;
  logic [7:0] page_i = 0, mode_i = 0;
  logic [15:0] addr_i = 0, cnt_i = 0;
  logic [23:0] mem_addr_o;
  logic dir_o, tc_o, chan_masked_o, casc_req_o, casc_ack_o;
  logic [15:0] cur_addr_o, cur_cnt_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dma_addr_gen u0 (.*);

  // reference state
  logic [7:0]  m_page = 0;
  logic [15:0] m_addr = 0, m_cnt = 0, m_baddr = 0, m_bcnt = 0;
  logic m_mask = 1, m_word = 0, m_casc = 0, m_auto = 0, m_dir = 0;
  logic m_tc = 0, m_req = 0, m_ack = 0;

  function automatic logic [23:0] exp_phys(logic [7:0] pg, logic [15:0] a, logic w);
    return w ? {pg[7:1], a, 1'b0} : {pg, a};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(logic ld, logic [7:0] pg, logic [15:0] ad, logic [15:0] cn,
                      logic [7:0] md, logic wd, logic xf, logic dq, logic hk);
    @(negedge clk);
    load_i = ld; page_i = pg; addr_i = ad; cnt_i = cn; mode_i = md;
    word_i = wd; xfer_i = xf; casc_req_i = dq; casc_ack_i = hk;
    @(posedge clk);
    m_req = m_casc & ~m_mask & dq;
    m_ack = m_casc & ~m_mask & hk;
    m_tc = 0;
    if (ld) begin
      m_page = pg; m_addr = ad; m_cnt = cn; m_baddr = ad; m_bcnt = cn;
      m_mask = 0; m_word = wd; m_casc = (md[7:6] == 2'b11);
      m_auto = md[4]; m_dir = md[3];
    end else if (xf && !m_mask && !m_casc) begin
      if (m_cnt == 0) begin
        m_tc = 1;
        if (m_auto) begin m_addr = m_baddr; m_cnt = m_bcnt; end
        else begin m_addr = m_addr + 1; m_cnt = 16'hFFFF; m_mask = 1; end
      end else begin
        m_addr = m_addr + 1; m_cnt = m_cnt - 1;
      end
    end
    #1;
    if (m_word) check("R3 word address", mem_addr_o, exp_phys(m_page, m_addr, 1));
    else        check("R2 byte address", mem_addr_o, exp_phys(m_page, m_addr, 0));
    check("R4 current address", cur_addr_o, m_addr);
    check("R4 current count", cur_cnt_o, m_cnt);
    check("R5 terminal count", tc_o, m_tc);
    check("R6 mask", chan_masked_o, m_mask);
    check("R9 direction", dir_o, m_dir);
    check("R10 cascade", {casc_req_o, casc_ack_o}, {m_req, m_ack});
  endtask

  task automatic idle_xfer();
    step(0, 0, 0, 0, 0, 0, 1, 0, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    check("R1 reset mask", chan_masked_o, 1);
    check("R1 reset tc", tc_o, 0);
    check("R1 reset address", mem_addr_o, 0);
    check("R1 reset cascade", {casc_req_o, casc_ack_o}, 0);

    // R8: strobes before any load leave registers alone
    idle_xfer();
    check("R8 masked hold", cur_addr_o, 0);

    // byte channel across the 64K wrap, count 2 -> three strobes
    step(1, 8'h12, 16'hFFFE, 16'd2, 8'h44, 0, 0, 0, 0);
    check("R11 load unmasks", chan_masked_o, 0);
    check("R2 loaded address", mem_addr_o, 24'h12FFFE);
    idle_xfer(); idle_xfer();
    check("R4 no page carry", mem_addr_o, 24'h120000);
    idle_xfer();
    check("R5 tc after N+1", tc_o, 1);
    check("R6 masked at tc", chan_masked_o, 1);
    idle_xfer();
    check("R8 hold after tc", cur_addr_o, 16'h0001);
    check("R5 tc single cycle", tc_o, 0);

    // word channel, odd page, mem-to-io
    step(1, 8'h35, 16'h8001, 16'd0, 8'h48, 1, 0, 0, 0);
    check("R3 word map odd page", mem_addr_o, 24'h350002);
    check("R9 mem to io", dir_o, 1);
    idle_xfer();
    check("R5 count zero one transfer", tc_o, 1);

    // autoinit with count 1
    step(1, 8'h07, 16'h1234, 16'd1, 8'h54, 0, 0, 0, 0);
    idle_xfer(); idle_xfer();
    check("R7 autoinit address", cur_addr_o, 16'h1234);
    check("R7 autoinit count", cur_cnt_o, 16'd1);
    check("R7 autoinit unmasked", chan_masked_o, 0);

    // cascade
    step(1, 8'h00, 16'h0100, 16'd3, 8'hC0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1, 1, 0);
    step(0, 0, 0, 0, 0, 0, 1, 1, 1);
    check("R10 cascade ignores strobes", cur_addr_o, 16'h0100);

    // load wins over strobe
    step(1, 8'hA0, 16'h4000, 16'd9, 8'h44, 0, 1, 0, 0);
    check("R11 load priority", cur_cnt_o, 16'd9);

    for (int i = 0; i < 4000; i++) begin
      logic [7:0] md;
      logic [15:0] ad;
      int pick = $urandom_range(0, 4);
      case (pick)
        0: md = 8'h44; 1: md = 8'h48; 2: md = 8'h54; 3: md = 8'h58; default: md = 8'hC0;
      endcase
      ad = ($urandom_range(0, 3) == 0) ? (16'hFFFF - 16'($urandom_range(0, 3))) : 16'($urandom);
      step(($urandom_range(0, 7) == 0), 8'($urandom), ad, 16'($urandom_range(0, 5)), md,
           1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule